// File: doc/BRIEF.md
# Serial Byte Link with Three-Sample Bit Voting

This block is a full-duplex asynchronous serial port for a small controller. Both directions share one oversampling tick, produced by a programmable clock divider. The tick runs at sixteen times the bit rate, so the bit rate is set by the divider value. A typical setting gives 57600 bit/s from the system clock. Every frame has these fields, in order: a low start bit, the data bits sent least significant first, one parity bit (even or odd, chosen at run time), and a high stop bit.

Each transmit byte is handed over on a valid/ready port. Each received byte is handed back on a second valid/ready port, together with three error flags.

The receiver votes on every bit of the frame, including the start and stop bits. It takes three samples one tick apart around the middle of the bit and keeps the majority value. A single disturbed sample therefore does not corrupt the data. However, any disagreement among the three samples is reported on a noise flag for that frame. A start edge whose middle samples vote high is dropped as a false start.

Top module: `uart3s_top`

## Requirements
- R1: One bit lasts 16*(baud_div+1) clock cycles. A frame with data 0x00 and even parity keeps the transmit line low for ten bit times.
- R2: The transmit line idles high, and tx_ready is high whenever the transmitter is idle. After a byte is accepted (tx_valid and tx_ready high at a clock edge), the next cycle has the line low (start bit) and tx_ready low. The data bits follow least significant first, then the parity bit, then a high stop bit. tx_ready returns high after the stop bit.
- R3: With par_odd=0 the parity bit equals the XOR of the data bits. With par_odd=1 it is the inverse of that XOR.
- R4: The receiver samples each bit at ticks 7, 8 and 9 of the bit's 16 ticks, counted from the start-edge tick as tick 0. It keeps the majority value, so a single disagreeing sample does not change the received byte.
- R5: rx_noise_err is 1 for a frame when, for any bit of that frame (start, data, parity or stop), the three samples are not all equal.
- R6: A low level on an idle line opens a frame. If the start bit votes high, the frame is discarded, rx_valid stays low, and the receiver waits for a new start.
- R7: rx_frame_err is 1 when the stop bit votes low.
- R8: rx_parity_err is 1 when the received parity bit does not match the parity that R3 defines for the received data and the current par_odd.
- R9: rx_valid, rx_data and the flags hold until rx_ready is high at a clock edge. rx_valid is low in the cycle after that edge. All three flags read 0 whenever rx_valid is low.
- R10: A frame that completes while rx_valid is still high is dropped, and the held byte is kept.
- R11: During and after reset, txd is 1, tx_ready is 1 and rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Tick period minus one, in clock cycles |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data and the flags are valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_noise_err | output | 1 | Some bit had disagreeing samples |
| rx_parity_err | output | 1 | Parity mismatch |
| rx_frame_err | output | 1 | Stop bit read as low |

## Verification
The receiver is tried with several kinds of frame:
- clean frames;
- frames where exactly one of the three middle samples is flipped, on the start, a data, the parity or the stop bit;
- frames with a wrong parity bit, or with a low stop bit;
- a short low pulse on an idle line.

Together these separate the majority vote from a plain single-sample read: the data stays correct while the noise flag rises. They also separate the noise flag from the parity and framing flags, and a true start from a false one.

The transmitter is checked on the line itself, at the middle of each bit and by the length of its low run. It is then looped back into the receiver. Back-to-back frames with no acknowledgement show that a held byte is kept.

// File: rtl/uart3s_pkg.sv
package uart3s_pkg;

   typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart3s_tick.sv
module uart3s_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/uart3s_tx.sv
module uart3s_tx #(
   parameter int DATA_BITS = 8,
   parameter int OVS       = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 par_odd,
   input  logic [DATA_BITS-1:0] data,
   input  logic                 valid,
   output logic                 ready,
   output logic                 txd
);
   localparam int PB    = PARITY_EN ? 1 : 0;
   localparam int FRAME = DATA_BITS + PB + 2;
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   logic [FRAME-1:0] shreg;
   logic [FRAME-1:0] frame_w;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] left;
   logic             busy;

   generate
      if (PARITY_EN) begin : g_par
         assign frame_w = {1'b1, (^data) ^ par_odd, data, 1'b0};
      end else begin : g_nopar
         logic unused_odd;
         assign unused_odd = par_odd;
         assign frame_w    = {1'b1, data, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         cnt   <= '0;
         left  <= '0;
         busy  <= 1'b0;
      end else if (!busy) begin
         if (valid) begin
            shreg <= frame_w;
            cnt   <= '0;
            left  <= IDX_W'(FRAME);
            busy  <= 1'b1;
         end
      end else if (tick) begin
         if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME-1:1]};
            left  <= left - 1'b1;
            if (left == IDX_W'(1)) busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign ready = !busy;
   assign txd   = shreg[0];
endmodule

// File: rtl/uart3s_rx.sv
module uart3s_rx
   import uart3s_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OVS       = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   input  logic                 par_odd,
   output logic                 done,
   output logic [DATA_BITS-1:0] data,
   output logic                 noise,
   output logic                 perr,
   output logic                 ferr
);
   localparam int PB    = PARITY_EN ? 1 : 0;
   localparam int FRAME = DATA_BITS + PB + 2;
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] S0   = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] S1   = CNT_W'(OVS / 2);
   localparam logic [CNT_W-1:0] S2   = CNT_W'(OVS / 2 + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME - 1);
   localparam logic [IDX_W-1:0] DLAST    = IDX_W'(DATA_BITS);

   logic [1:0]           sync;
   logic                 rx_s;
   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic                 smp0, smp1, par_q, nacc;
   logic [DATA_BITS-1:0] shreg;
   logic                 bit_v, bit_nz, par_bad;

   assign rx_s   = sync[1];
   assign bit_v  = maj3(smp0, smp1, rx_s);
   assign bit_nz = !((smp0 == smp1) && (smp1 == rx_s));

   generate
      if (PARITY_EN) begin : g_par
         assign par_bad = (^shreg) ^ par_q ^ par_odd;
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_q ^ par_odd;
         assign par_bad    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= 2'b11;
         state <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         smp0  <= 1'b1;
         smp1  <= 1'b1;
         par_q <= 1'b0;
         nacc  <= 1'b0;
         shreg <= '0;
         done  <= 1'b0;
         data  <= '0;
         noise <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         sync <= {sync[0], rxd};
         done <= 1'b0;
         if (tick) begin
            if (state == RX_IDLE) begin
               if (!rx_s) begin
                  state <= RX_RUN;
                  cnt   <= CNT_W'(1);
                  idx   <= '0;
                  nacc  <= 1'b0;
               end
            end else begin
               if (cnt == LAST) begin
                  cnt <= '0;
                  idx <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               if (cnt == S0) smp0 <= rx_s;
               if (cnt == S1) smp1 <= rx_s;
               if (cnt == S2) begin
                  nacc <= nacc | bit_nz;
                  if (idx == '0) begin
                     if (bit_v) state <= RX_IDLE;
                  end else if (idx == STOP_IDX) begin
                     state <= RX_IDLE;
                     done  <= 1'b1;
                     data  <= shreg;
                     noise <= nacc | bit_nz;
                     perr  <= par_bad;
                     ferr  <= !bit_v;
                  end else if (idx <= DLAST) begin
                     shreg <= {bit_v, shreg[DATA_BITS-1:1]};
                  end else begin
                     par_q <= bit_v;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/uart3s_top.sv
module uart3s_top #(
   parameter int DATA_BITS = 8,
   parameter int OVS       = 16,
   parameter int DIV_W     = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_W-1:0]     baud_div,
   input  logic                 par_odd,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   output logic                 txd,
   input  logic                 rxd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   input  logic                 rx_ready,
   output logic                 rx_noise_err,
   output logic                 rx_parity_err,
   output logic                 rx_frame_err
);
   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 8");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_data
         $error("DATA_BITS must lie in 5..9");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be positive");
      end
   endgenerate

   logic                 tick;
   logic                 rx_done, rx_nz, rx_pe, rx_fe;
   logic [DATA_BITS-1:0] rx_word;

   uart3s_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
   );

   uart3s_tx #(.DATA_BITS(DATA_BITS), .OVS(OVS), .PARITY_EN(PARITY_EN)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .par_odd(par_odd),
      .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
   );

   uart3s_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS), .PARITY_EN(PARITY_EN)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_odd(par_odd),
      .done(rx_done), .data(rx_word), .noise(rx_nz), .perr(rx_pe), .ferr(rx_fe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid      <= 1'b0;
         rx_data       <= '0;
         rx_noise_err  <= 1'b0;
         rx_parity_err <= 1'b0;
         rx_frame_err  <= 1'b0;
      end else if (rx_valid) begin
         if (rx_ready) begin
            rx_valid      <= 1'b0;
            rx_noise_err  <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
         end
      end else if (rx_done) begin
         rx_valid      <= 1'b1;
         rx_data       <= rx_word;
         rx_noise_err  <= rx_nz;
         rx_parity_err <= rx_pe;
         rx_frame_err  <= rx_fe;
      end
   end
endmodule

// File: rtl/uart3s_chk.sv
module uart3s_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 txd,
   input logic                 tx_valid,
   input logic                 tx_ready,
   input logic                 rx_valid,
   input logic                 rx_ready,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_noise_err,
   input logic                 rx_parity_err,
   input logic                 rx_frame_err
);
   AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> txd); // R2
   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !txd && !tx_ready); // R2
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R10
   AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready |=> !rx_valid); // R9
   AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> !(rx_noise_err || rx_parity_err || rx_frame_err)); // R9
endmodule

bind uart3s_top uart3s_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
   .rx_noise_err(rx_noise_err), .rx_parity_err(rx_parity_err),
   .rx_frame_err(rx_frame_err)
);

// File: tb/tb_uart3s_top.sv
module tb_uart3s_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] baud_div = 16'd3;
   logic        par_odd = 1'b0;
   logic [7:0]  tx_data = 8'h00;
   logic        tx_valid = 1'b0;
   logic        tx_ready, txd;
   logic        rx_drv = 1'b1;
   logic        loop = 1'b0;
   logic        rxd_w;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_ready = 1'b0;
   logic        rx_noise_err, rx_parity_err, rx_frame_err;
   int          total = 0;
   int          fails = 0;

   always #5 clk = ~clk;
   assign rxd_w = loop ? txd : rx_drv;

   uart3s_top dut (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .par_odd(par_odd),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
      .rxd(rxd_w), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_noise_err(rx_noise_err), .rx_parity_err(rx_parity_err),
      .rx_frame_err(rx_frame_err)
   );

   // {data[14:7], odd[6], glitch bit[5:2] (15 = none), bad parity[1], low stop[0]}
   localparam logic [14:0] VEC [0:7] = '{
      {8'h55, 1'b0, 4'd15, 1'b0, 1'b0},
      {8'hA3, 1'b1, 4'd3,  1'b0, 1'b0},
      {8'h00, 1'b0, 4'd0,  1'b0, 1'b0},
      {8'hFF, 1'b1, 4'd10, 1'b0, 1'b0},
      {8'h81, 1'b0, 4'd15, 1'b1, 1'b0},
      {8'h7E, 1'b1, 4'd15, 1'b0, 1'b1},
      {8'h1F, 1'b0, 4'd9,  1'b1, 1'b0},
      {8'hC4, 1'b1, 4'd8,  1'b0, 1'b0}
   };

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // drive one frame on rxd, 64 clocks per bit; one sample flipped on bit glitch
   task automatic send_rx(input logic [7:0] d, input logic odd, input int glitch,
                          input logic badpar, input logic lowstop);
      logic [10:0] bits;
      bits = {~lowstop, (^d) ^ odd ^ badpar, d, 1'b0};
      for (int k = 0; k < 11; k++) begin
         for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            rx_drv = (glitch == k && c >= 32 && c < 36) ? ~bits[k] : bits[k];
         end
      end
      @(negedge clk);
      rx_drv = 1'b1;
      repeat (100) @(negedge clk);
   endtask

   task automatic ack_rx();
      @(negedge clk);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      check(!rx_valid && !rx_noise_err && !rx_parity_err && !rx_frame_err,
            "R9 cleared after ack", {rx_valid, rx_noise_err, rx_parity_err, rx_frame_err}, 0);
   endtask

   task automatic offer_tx(input logic [7:0] d);
      @(negedge clk);
      tx_data  = d;
      tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int lowcnt;
      logic [10:0] exp_bits;
      // R11 reset state
      repeat (3) @(negedge clk);
      check(txd && tx_ready && !rx_valid, "R11 in reset", {txd, tx_ready, rx_valid}, 3'b110);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(txd && tx_ready && !rx_valid, "R11 after reset", {txd, tx_ready, rx_valid}, 3'b110);

      // table of received frames: R4 R5 R7 R8
      for (int i = 0; i < 8; i++) begin
         par_odd = VEC[i][6];
         send_rx(VEC[i][14:7], VEC[i][6], int'(VEC[i][5:2]), VEC[i][1], VEC[i][0]);
         check(rx_valid, "R4 frame delivered", rx_valid, 1);
         check(rx_data == VEC[i][14:7], "R4 majority data", rx_data, VEC[i][14:7]);
         check(rx_noise_err == (VEC[i][5:2] != 4'd15), "R5 noise flag",
               rx_noise_err, VEC[i][5:2] != 4'd15);
         check(rx_parity_err == VEC[i][1], "R8 parity flag", rx_parity_err, VEC[i][1]);
         check(rx_frame_err == VEC[i][0], "R7 framing flag", rx_frame_err, VEC[i][0]);
         ack_rx();
      end

      // R6 false start: short low pulse
      par_odd = 1'b0;
      @(negedge clk);
      rx_drv = 1'b0;
      repeat (8) @(negedge clk);
      rx_drv = 1'b1;
      repeat (200) @(negedge clk);
      check(!rx_valid, "R6 false start dropped", rx_valid, 0);
      send_rx(8'h96, 1'b0, 15, 1'b0, 1'b0);
      check(rx_valid && rx_data == 8'h96 && !rx_noise_err, "R6 recovery after false start",
            rx_data, 8'h96);

      // R9 hold and R10 drop of a second frame
      repeat (50) @(negedge clk);
      check(rx_valid && rx_data == 8'h96, "R9 held without ack", rx_data, 8'h96);
      send_rx(8'h22, 1'b0, 15, 1'b0, 1'b0);
      check(rx_valid && rx_data == 8'h96, "R10 later frame dropped", rx_data, 8'h96);
      ack_rx();
      repeat (100) @(negedge clk);
      check(!rx_valid, "R10 dropped frame not delivered", rx_valid, 0);

      // R2 R3 transmit waveform, even and odd parity
      for (int p = 0; p < 2; p++) begin
         par_odd  = p[0];
         exp_bits = {1'b1, (^8'h5A) ^ p[0], 8'h5A, 1'b0};
         offer_tx(8'h5A);
         check(!tx_ready && !txd, "R2 busy and start after accept", {tx_ready, txd}, 0);
         for (int c = 2; c < 704; c++) begin
            @(negedge clk);
            if (c % 64 == 30)
               check(txd == exp_bits[c / 64], c / 64 == 9 ? "R3 parity bit" : "R2 frame bit",
                     txd, exp_bits[c / 64]);
         end
         repeat (20) @(negedge clk);
         check(tx_ready && txd, "R2 idle after stop", {tx_ready, txd}, 3);
      end

      // R1 bit time via low run of 0x00 with even parity
      par_odd = 1'b0;
      lowcnt  = 0;
      offer_tx(8'h00);
      lowcnt = txd ? 0 : 1;
      for (int c = 0; c < 800; c++) begin
         @(negedge clk);
         if (!txd) lowcnt++;
      end
      check(lowcnt >= 636 && lowcnt <= 641, "R1 ten bit times low", lowcnt, 640);

      // loopback, both parities
      loop = 1'b1;
      for (int p = 0; p < 2; p++) begin
         par_odd = p[0];
         offer_tx(p[0] ? 8'hA5 : 8'h3C);
         repeat (740) @(negedge clk);
         check(rx_valid && rx_data == (p[0] ? 8'hA5 : 8'h3C) && !rx_noise_err &&
               !rx_parity_err && !rx_frame_err, "R3 loopback frame", rx_data,
               p[0] ? 8'hA5 : 8'h3C);
         ack_rx();
      end
      summary();
   end
endmodule